// File: doc/BRIEF.md
# Sign-Steered Operand Ordering Multiplier

This block sits in front of a signed array multiplier and decides, for every accepted operand pair, which operand goes to which multiplier port. Switching inside an array multiplier is driven mostly by how the operand signs change from one multiplication to the next. The block keeps the pair that is currently held on the multiplier ports. It counts how many port sign bits would flip if the new pair went in straight, and how many would flip if it went in crossed, then loads the order with fewer flips. Multiplication is commutative, so the product is the same in either order.

Operand pairs arrive as a stream qualified by `in_valid`. A pair is registered onto the multiplier ports together with the chosen order on the clock edge that accepts it. The signed product is registered one edge later, and `out_valid` travels with it. `swap_state` shows the order that is currently registered, so a model can follow the decisions.

Top module: `opswap_mul`

## Requirements
- R1: While reset is asserted, and after it is released before any pair is accepted, `swap_state` is 0, `out_valid` is 0 and `out_product` is 0.
- R2: Every `out_product` qualified by `out_valid` equals the full-width signed product of `in_a` and `in_b` from the accepted pair, whatever order that pair was loaded in.
- R3: A pair accepted on a rising edge with `in_valid` high produces `out_valid` high after the next rising edge. `out_valid` is low after any edge whose previous edge accepted no pair.
- R4: The sign of an operand is its most significant bit. With P1 and P2 the values held on port 1 and port 2, the straight cost is [sign(in_a)≠sign(P1)] + [sign(in_b)≠sign(P2)] and the crossed cost is [sign(in_b)≠sign(P1)] + [sign(in_a)≠sign(P2)]. An accepted pair is loaded crossed (`swap_state`=1, in_b to port 1) when the crossed cost is lower. It is loaded straight (`swap_state`=0) when the straight cost is lower.
- R5: When the two costs are equal, the accepted pair is loaded in the order already held, and `swap_state` keeps its value.
- R6: On an edge with `in_valid` low, the inputs are ignored: the held port values and `swap_state` do not change, and `out_product` keeps its last value.
- R7: After reset both held port values are zero and count as non-negative, so the first accepted pair is a tie and is loaded straight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies `in_a`/`in_b` on this edge |
| in_a | input | 16 | First signed operand |
| in_b | input | 16 | Second signed operand |
| out_valid | output | 1 | `out_product` holds a new result |
| out_product | output | 32 | Signed product of the pair |
| swap_state | output | 1 | Order currently held on the multiplier ports (1 = crossed) |

## Verification
The crossed order is reached only when both the incoming pair and the held pair have mixed signs. The tie rule can only be seen to keep a crossed order after such a crossing has been set up. Random operands rarely line up like this. The stimulus therefore walks every sequence of three sign classes (both non-negative, a negative only, b negative only, both negative), so every held order meets every incoming class. Magnitudes come from a shift register, and idle cycles with deliberately provoking inputs are mixed in, so the hold rules are also tested from the crossed state.

// File: rtl/opswap_pkg.sv
package opswap_pkg;

  typedef enum logic {
    ORDER_STRAIGHT = 1'b0,
    ORDER_CROSSED  = 1'b1
  } order_e;

  // Number of sign bits that toggle on the two ports (0..2).
  function automatic logic [1:0] sign_flips(input logic to_p1, input logic to_p2,
                                            input logic held_p1, input logic held_p2);
    return {1'b0, to_p1 ^ held_p1} + {1'b0, to_p2 ^ held_p2};
  endfunction

endpackage

// File: rtl/opswap_rst_sync.sv
module opswap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/opswap_estimator.sv
module opswap_estimator
  import opswap_pkg::*;
#(
  parameter int W        = 16,
  parameter bit TIE_KEEP = 1'b1
) (
  input  logic [W-1:0] new_a,
  input  logic [W-1:0] new_b,
  input  logic [W-1:0] held_p1,
  input  logic [W-1:0] held_p2,
  input  order_e       cur_order,
  output order_e       next_order,
  output logic         tie
);

  localparam int SB = W - 1;

  logic       s_a, s_b, s_h1, s_h2;
  logic [1:0] cost_straight, cost_crossed;
  order_e     tie_order;

  assign s_a  = new_a[SB];
  assign s_b  = new_b[SB];
  assign s_h1 = held_p1[SB];
  assign s_h2 = held_p2[SB];

  assign cost_straight = sign_flips(s_a, s_b, s_h1, s_h2);
  assign cost_crossed  = sign_flips(s_b, s_a, s_h1, s_h2);

  generate
    if (TIE_KEEP) begin : g_tie_keep
      assign tie_order = cur_order;
    end else begin : g_tie_straight
      assign tie_order = ORDER_STRAIGHT;
    end
  endgenerate

  always_comb begin
    tie = (cost_crossed == cost_straight);
    if (cost_crossed < cost_straight)      next_order = ORDER_CROSSED;
    else if (cost_straight < cost_crossed) next_order = ORDER_STRAIGHT;
    else                                   next_order = tie_order;
  end

  // R4: a strict decision never raises the flip count
  always_comb begin
    if (!tie) begin
      a_cost_r4: assert ((next_order == ORDER_CROSSED) ? (cost_crossed < cost_straight)
                                                       : (cost_straight < cost_crossed));
    end
  end

endmodule

// File: rtl/opswap_oper_reg.sv
module opswap_oper_reg
  import opswap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         tie,
  input  logic [W-1:0] new_a,
  input  logic [W-1:0] new_b,
  input  order_e       next_order,
  output logic [W-1:0] port1,
  output logic [W-1:0] port2,
  output order_e       order_q,
  output logic         stage_v
);

  logic [W-1:0] p1_q, p2_q, p1_d, p2_d;
  order_e       ord_d;
  logic         v_q;

  always_comb begin
    p1_d  = p1_q;
    p2_d  = p2_q;
    ord_d = order_q;
    if (load) begin
      ord_d = next_order;
      if (next_order == ORDER_CROSSED) begin
        p1_d = new_b;
        p2_d = new_a;
      end else begin
        p1_d = new_a;
        p2_d = new_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q    <= '0;
      p2_q    <= '0;
      order_q <= ORDER_STRAIGHT;
      v_q     <= 1'b0;
    end else begin
      v_q <= load;
      if (load) begin
        p1_q    <= p1_d;
        p2_q    <= p2_d;
        order_q <= ord_d;
      end
    end
  end

  assign port1   = p1_q;
  assign port2   = p2_q;
  assign stage_v = v_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(order_q) && $stable(p1_q) && $stable(p2_q)));

  p_tie_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tie) |=> (order_q == $past(order_q)));

endmodule

// File: rtl/opswap_mult_stage.sv
module opswap_mult_stage #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stage_v,
  input  logic [W-1:0]   port1,
  input  logic [W-1:0]   port2,
  output logic [2*W-1:0] product,
  output logic           prod_v
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0] ext1, ext2, prod_d;
  logic        [PW-1:0] prod_q;
  logic                 v_q;

  assign ext1 = $signed({{W{port1[W-1]}}, port1});
  assign ext2 = $signed({{W{port2[W-1]}}, port2});

  always_comb begin
    prod_d = stage_v ? (ext1 * ext2) : $signed(prod_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      v_q    <= 1'b0;
    end else begin
      v_q <= stage_v;
      if (stage_v) prod_q <= prod_d;
    end
  end

  assign product = prod_q;
  assign prod_v  = v_q;

  p_prod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_v |=> $stable(prod_q));

endmodule

// File: rtl/opswap_mul.sv
module opswap_mul
  import opswap_pkg::*;
#(
  parameter int W        = 16,
  parameter bit TIE_KEEP = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_product,
  output logic           swap_state
);

  localparam int PW = 2 * W;

  logic         rst_n_i;
  logic [W-1:0] port1, port2;
  order_e       order_q, next_order;
  logic         tie, stage_v;

  opswap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  opswap_estimator #(.W(W), .TIE_KEEP(TIE_KEEP)) u_est (
    .new_a      (in_a),
    .new_b      (in_b),
    .held_p1    (port1),
    .held_p2    (port2),
    .cur_order  (order_q),
    .next_order (next_order),
    .tie        (tie)
  );

  opswap_oper_reg #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load       (in_valid),
    .tie        (tie),
    .new_a      (in_a),
    .new_b      (in_b),
    .next_order (next_order),
    .port1      (port1),
    .port2      (port2),
    .order_q    (order_q),
    .stage_v    (stage_v)
  );

  opswap_mult_stage #(.W(W)) u_mult (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .stage_v (stage_v),
    .port1   (port1),
    .port2   (port2),
    .product (out_product),
    .prod_v  (out_valid)
  );

  assign swap_state = (order_q == ORDER_CROSSED);

  logic signed [PW-1:0] in_ext_a, in_ext_b, in_prod;
  assign in_ext_a = $signed({{W{in_a[W-1]}}, in_a});
  assign in_ext_b = $signed({{W{in_b[W-1]}}, in_b});
  assign in_prod  = in_ext_a * in_ext_b;

  p_product_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_valid |-> (out_product == $past(in_prod, 2)));

  p_valid_pipe_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    stage_v |=> out_valid);

  p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    !stage_v |=> !out_valid);

  p_port_pair_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_valid |=> ((port1 == $past(in_a) && port2 == $past(in_b)) ||
                  (port1 == $past(in_b) && port2 == $past(in_a))));

endmodule

// File: tb/sim_opswap_mul.sv
module sim_opswap_mul;

  localparam int W  = 16;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic [PW-1:0] out_product;
  logic          swap_state;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opswap_mul u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_product (out_product),
    .swap_state  (swap_state)
  );

  // reference state
  logic [W-1:0]  m_p1 = '0, m_p2 = '0;
  logic          m_swap = 1'b0;
  logic          prev_v = 1'b0;
  logic [PW-1:0] prev_prod = '0;
  logic [PW-1:0] last_prod = '0;
  bit            first_pair = 1'b1;
  logic [31:0]   lf = 32'h1ACE_B00C;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return PW'(sa * sb);
  endfunction

  task automatic rnd(output logic [W-1:0] v);
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    v = lf[W-1:0];
  endtask

  // pattern bit1: a negative, bit0: b negative
  task automatic make_pair(input int pat, output logic [W-1:0] a, output logic [W-1:0] b);
    logic [W-1:0] r;
    rnd(r);
    a = pat[1] ? (r | 16'h8000) : (r & 16'h7FFF);
    rnd(r);
    b = pat[0] ? (r | 16'h8000) : (r & 16'h7FFF);
  endtask

  task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b);
    int    cs, cc;
    string tag;
    in_valid = v;
    in_a = a;
    in_b = b;
    tag = "R6";
    if (v) begin
      cs = int'(a[W-1] != m_p1[W-1]) + int'(b[W-1] != m_p2[W-1]);
      cc = int'(b[W-1] != m_p1[W-1]) + int'(a[W-1] != m_p2[W-1]);
      if (first_pair)   tag = "R7";
      else if (cc != cs) tag = "R4";
      else              tag = "R5";
      if (cc < cs)      m_swap = 1'b1;
      else if (cs < cc) m_swap = 1'b0;
      m_p1 = m_swap ? b : a;
      m_p2 = m_swap ? a : b;
      first_pair = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(swap_state === m_swap, tag, longint'(swap_state), longint'(m_swap));
    chk(out_valid === prev_v, "R3", longint'(out_valid), longint'(prev_v));
    if (prev_v) begin
      chk(out_product === prev_prod, "R2", longint'(out_product), longint'(prev_prod));
      last_prod = prev_prod;
    end else begin
      chk(out_product === last_prod, "R6", longint'(out_product), longint'(last_prod));
    end
    prev_v = v;
    if (v) prev_prod = smul(a, b);
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    repeat (3) @(negedge clk);
    chk(swap_state === 1'b0 && out_valid === 1'b0 && out_product === '0, "R1",
        longint'({swap_state, out_valid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(swap_state === 1'b0 && out_valid === 1'b0 && out_product === '0, "R1",
        longint'(out_product), 0);

    // first pair after reset: mixed signs against zeroed ports, a tie (R7)
    step(1'b1, 16'hFFFB, 16'h0007);

    // all three-deep sign class sequences, with provoking idle cycles (R4 R5 R6)
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        for (int k = 0; k < 4; k++) begin
          make_pair(i, a, b); step(1'b1, a, b);
          make_pair(j, a, b); step(1'b1, a, b);
          if (((i + j + k) % 3) == 0) begin
            make_pair(3 - k, a, b); step(1'b0, a, b);
            make_pair(k ^ 1, a, b); step(1'b0, a, b);
          end
          make_pair(k, a, b); step(1'b1, a, b);
        end
      end
    end

    // arithmetic corners (R2)
    step(1'b1, 16'h8000, 16'h8000);
    step(1'b1, 16'h7FFF, 16'h8000);
    step(1'b1, 16'h8000, 16'h7FFF);
    step(1'b1, 16'h0000, 16'hFFFF);
    step(1'b1, 16'hFFFF, 16'hFFFF);
    step(1'b1, 16'h7FFF, 16'h7FFF);
    step(1'b0, 16'h8000, 16'h1234);
    step(1'b0, 16'h0000, 16'h0000);
    step(1'b0, 16'h0000, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule